// File: doc/BRIEF.md
# Two-Queue Credit-Based Transmit Shaper

This block decides when each of the two highest-priority transmit queues may start a frame. Each queue can be left unshaped, so it may send whenever it holds a frame. It can also be bound to its own credit engine, which follows the IEEE 802.1Qav scheme. Credit rises at a programmable idle rate while the queue waits or while someone else is on the wire. It falls at a fixed send rate while the queue's own frame goes out. A frame may start only when the credit is zero or positive. Time runs in byte ticks supplied from outside. All credit arithmetic is done in fixed units, where one byte equals 2 x 0x7735 = 61034 units.

Software configures a queue by writing three values together: a 2-bit select code, a 16-bit idle slope with a keep-credits flag, and a 32-bit high-credit word. The block checks two ordering rules between the queues and refuses any write that breaks them. A refused write leaves the settings unchanged. The send slope and the low-credit floor are fixed when the block is built (parameters `SEND_STEP` and `LO_CREDIT`). A single fixed-priority arbiter turns the per-queue eligibility into a one-hot grant. The grant is held until the transmitter drops its busy flag.

Top module: `credit_shaper`

## Requirements
- R1: After reset, no grant is given and both queues are unshaped.
- R2: An unshaped queue is eligible whenever its pending bit is set and its frame length is non-zero. A queue whose frame length is zero is never eligible.
- R3: The grant is one-hot or zero. When both queues are eligible and no grant is held, grant[0] is given (value 2'b01).
- R4: A new grant is given one cycle after eligibility, and only while `tx_busy` is low. A held grant stays until `tx_busy` falls, and clears in the cycle after the fall.
- R5: Select code 2'b10 with queue 0, or code 2'b11 with queue 1, enables shaping. Code 2'b00 disables shaping. Code 2'b01, or a code that names the other queue's shaper, is refused.
- R6: Enabling queue 1 while queue 0 is unshaped is refused. Disabling queue 0 while queue 1 is shaped is refused. A refused write changes no setting.
- R7: An enabling write whose high-credit word has bit 31 clear is refused. The credit ceiling is bits 30:0 of the word times two units.
- R8: A shaped queue that is pending with negative credit gains the idle-slope value in units on every tick, and becomes eligible once its credit is zero or more.
- R9: On each tick while its own frame is sent (`tx_busy` high with its grant held), a shaped queue loses `SEND_STEP` units, never going below `LO_CREDIT`.
- R10: A shaped queue that is pending while another transmission is busy gains the idle slope per tick, saturating at the ceiling.
- R11: A tick with no pending frame and positive credit clears the credit unless keep-credits is set. An accepted enabling write clears the credit unless its keep-credits is set.
- R12: An accepted disabling write clears the idle slope, keep-credits and ceiling, and the queue then behaves as unshaped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_queue | input | 1 | Queue addressed by the write |
| cfg_sel | input | 2 | Shaper select code (00 off, 10 shaper 0, 11 shaper 1) |
| cfg_idle_slope | input | 16 | Idle slope, units added per tick |
| cfg_keep | input | 1 | Keep-credits flag |
| cfg_hicredit | input | 32 | High-credit word, bit 31 set when enabling |
| frame_pending | input | 2 | Per-queue frame waiting |
| frame_len | input | 2*LEN_W | Per-queue frame length, queue 0 in the low bits |
| tx_busy | input | 1 | Transmitter busy with the granted frame |
| byte_tick | input | 1 | One-cycle byte-time strobe |
| grant | output | 2 | One-hot transmit grant, bit 0 for queue 0 |

## Verification
The hardest cases to reach are those where the credit limits come into play. One is the ceiling, which a queue only hits after it has waited through a long frame from the other queue. The other is the difference between keeping and clearing a positive credit. The stimulus builds these states on purpose. It first sends a frame from one queue so the other goes negative. It then lets the other queue build up credit behind a long frame. Finally it sends a measured frame and counts the ticks until the grant comes back. Randomly chosen slopes and frame lengths run against an exact tick count computed in the bench. Refused writes are told apart from accepted ones by whether a queue is granted again at once after a frame.

// File: rtl/credit_shaper_pkg.sv
// Shared constants and the per-queue shaping configuration record.
package credit_shaper_pkg;
    localparam int NUM_SHAPED = 2;
    localparam int SLOPE_W    = 16;
    localparam int HI_W       = 32;
    localparam int SEL_W      = 2;
    localparam logic [SEL_W-1:0] SEL_OFF = 2'b00;
    localparam logic [SEL_W-1:0] SEL_S0  = 2'b10;
    localparam logic [SEL_W-1:0] SEL_S1  = 2'b11;

    typedef struct packed {
        logic               en;
        logic               keep;
        logic [SLOPE_W-1:0] slope;
        logic [HI_W-2:0]    hi_mag;
    } shp_cfg_t;
endpackage

// File: rtl/credit_shaper_cfg.sv
// Holds the shaping settings of both queues and applies the write rules.
// Assumes cfg_wr is a single-cycle strobe; refused writes change nothing.
module credit_shaper_cfg
    import credit_shaper_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_queue,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [SLOPE_W-1:0] cfg_idle_slope,
    input  logic               cfg_keep,
    input  logic [HI_W-1:0]    cfg_hicredit,
    output shp_cfg_t           cfg_q [NUM_SHAPED],
    output logic [NUM_SHAPED-1:0] clr_q
);
    logic want_on, want_off, acc_on, acc_off;

    // Decide whether the current write is accepted.
    always_comb begin
        want_on  = (!cfg_queue && cfg_sel == SEL_S0) || (cfg_queue && cfg_sel == SEL_S1);
        want_off = (cfg_sel == SEL_OFF);
        acc_on   = cfg_wr && want_on && cfg_hicredit[HI_W-1] && (!cfg_queue || cfg_q[0].en);
        acc_off  = cfg_wr && want_off && (cfg_queue || !cfg_q[1].en);
    end

    // Request a credit clear on disable, or on enable without keep-credits.
    always_comb begin
        for (int i = 0; i < NUM_SHAPED; i++) begin
            clr_q[i] = (cfg_queue == 1'(i)) && (acc_off || (acc_on && !cfg_keep));
        end
    end

    // Store accepted settings; disable zeroes every field.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SHAPED; i++) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (cfg_queue == 1'(i)) begin
                if (acc_on) begin
                    cfg_q[i].en     <= 1'b1;
                    cfg_q[i].keep   <= cfg_keep;
                    cfg_q[i].slope  <= cfg_idle_slope;
                    cfg_q[i].hi_mag <= cfg_hicredit[HI_W-2:0];
                end else if (acc_off) begin
                    cfg_q[i] <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/credit_shaper_lane.sv
// Credit engine for one queue. Credit is signed, one byte = 61034 units.
// Assumes CW is wide enough that ceiling plus slope never overflows.
module credit_shaper_lane
    import credit_shaper_pkg::*;
#(
    parameter int CW        = 36,
    parameter int SEND_STEP = 61036,
    parameter int LO_CREDIT = -92896792
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               shaped,
    input  logic               keep,
    input  logic [SLOPE_W-1:0] slope,
    input  logic [HI_W-2:0]    hi_mag,
    input  logic               clr,
    input  logic               pending,
    input  logic               len_nz,
    input  logic               own_tx,
    input  logic               other_tx,
    output logic signed [CW-1:0] credit,
    output logic               eligible
);
    localparam logic signed [CW-1:0] SEND_C = CW'(SEND_STEP);
    localparam logic signed [CW-1:0] LO_C   = CW'(LO_CREDIT);

    logic signed [CW-1:0] hi_c, up, dn, nxt;

    // Ceiling in units and the two candidate step results.
    always_comb begin
        hi_c = $signed({{(CW-HI_W){1'b0}}, hi_mag, 1'b0});
        up   = credit + $signed({{(CW-SLOPE_W){1'b0}}, slope});
        dn   = credit - SEND_C;
    end

    // Next credit value per tick.
    always_comb begin
        nxt = credit;
        if (!shaped || clr) begin
            nxt = '0;
        end else if (tick) begin
            if (own_tx) begin
                nxt = (dn < LO_C) ? LO_C : dn;
            end else if (pending) begin
                if (credit < 0 || other_tx) nxt = (up > hi_c) ? hi_c : up;
            end else if (credit < 0) begin
                nxt = (up > 0) ? '0 : up;
            end else if (credit > 0 && !keep) begin
                nxt = '0;
            end
        end
    end

    // Credit register.
    always_ff @(posedge clk) begin
        if (!rst_n) credit <= '0;
        else        credit <= nxt;
    end

    // A frame may start only with non-negative credit.
    assign eligible = pending && len_nz && (!shaped || !credit[CW-1]);
endmodule

// File: rtl/credit_shaper_arb.sv
// Fixed-priority grant, lowest index first, held until tx_busy falls.
// Assumes the transmitter raises tx_busy only for a granted frame.
module credit_shaper_arb #(
    parameter int NQ = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_busy,
    input  logic [NQ-1:0] elig,
    output logic [NQ-1:0] grant
);
    logic          busy_d;
    logic [NQ-1:0] pick;

    // Select the lowest-index eligible queue.
    always_comb begin
        pick = '0;
        for (int i = NQ-1; i >= 0; i--) begin
            if (elig[i]) pick = NQ'(1) << i;
        end
    end

    // Issue, hold and release the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant  <= '0;
            busy_d <= 1'b0;
        end else begin
            busy_d <= tx_busy;
            if (grant != '0) begin
                if (busy_d && !tx_busy) grant <= '0;
            end else if (!tx_busy) begin
                grant <= pick;
            end
        end
    end
endmodule

// File: rtl/credit_shaper.sv
// Two-queue credit-based shaper: configuration, two credit lanes, arbiter.
// Assumes byte_tick is a one-cycle strobe per byte time.
module credit_shaper
    import credit_shaper_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int CW        = 36,
    parameter int SEND_STEP = 61036,
    parameter int LO_CREDIT = -92896792
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic                       cfg_queue,
    input  logic [SEL_W-1:0]           cfg_sel,
    input  logic [SLOPE_W-1:0]         cfg_idle_slope,
    input  logic                       cfg_keep,
    input  logic [HI_W-1:0]            cfg_hicredit,
    input  logic [NUM_SHAPED-1:0]      frame_pending,
    input  logic [NUM_SHAPED*LEN_W-1:0] frame_len,
    input  logic                       tx_busy,
    input  logic                       byte_tick,
    output logic [NUM_SHAPED-1:0]      grant
);
    localparam int NQ = NUM_SHAPED;

    shp_cfg_t             cfg_q [NQ];
    logic [NQ-1:0]        clr_q;
    logic [NQ-1:0]        elig_q;
    logic [NQ-1:0]        shaped_q;
    logic [NQ*CW-1:0]     credit_flat;

    credit_shaper_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_queue(cfg_queue),
        .cfg_sel(cfg_sel), .cfg_idle_slope(cfg_idle_slope), .cfg_keep(cfg_keep),
        .cfg_hicredit(cfg_hicredit), .cfg_q(cfg_q), .clr_q(clr_q)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_lane
        credit_shaper_lane #(.CW(CW), .SEND_STEP(SEND_STEP), .LO_CREDIT(LO_CREDIT)) u_lane (
            .clk(clk), .rst_n(rst_n), .tick(byte_tick),
            .shaped(cfg_q[g].en), .keep(cfg_q[g].keep),
            .slope(cfg_q[g].slope), .hi_mag(cfg_q[g].hi_mag),
            .clr(clr_q[g]), .pending(frame_pending[g]),
            .len_nz(|frame_len[g*LEN_W +: LEN_W]),
            .own_tx(tx_busy & grant[g]), .other_tx(tx_busy & ~grant[g]),
            .credit(credit_flat[g*CW +: CW]), .eligible(elig_q[g])
        );
        assign shaped_q[g] = cfg_q[g].en;
    end

    credit_shaper_arb #(.NQ(NQ)) u_arb (
        .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .elig(elig_q), .grant(grant)
    );
endmodule

// File: rtl/credit_shaper_chk.sv
// Assertion checker for credit_shaper, attached by bind.
module credit_shaper_chk #(
    parameter int CW        = 36,
    parameter int LO_CREDIT = -92896792
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_busy,
    input logic [1:0]    grant,
    input logic [1:0]    elig,
    input logic [1:0]    shaped,
    input logic [2*CW-1:0] credit_flat
);
    logic signed [CW-1:0] c0, c1;
    assign c0 = credit_flat[CW-1:0];
    assign c1 = credit_flat[2*CW-1:CW];

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R3
    AST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b00 && !tx_busy && elig == 2'b11) |=> grant == 2'b01); // R3
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 2'b00 && tx_busy) |=> $stable(grant)); // R4
    AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b00 && tx_busy) |=> grant == 2'b00); // R4
    AST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        shaped[1] |-> shaped[0]); // R6
    AST_GRANT_NONNEG0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant[0]) |-> !c0[CW-1]); // R8
    AST_GRANT_NONNEG1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant[1]) |-> !c1[CW-1]); // R8
    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (c0 >= LO_CREDIT) && (c1 >= LO_CREDIT)); // R9
endmodule

bind credit_shaper credit_shaper_chk #(.CW(CW), .LO_CREDIT(LO_CREDIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .grant(grant),
    .elig(elig_q), .shaped(shaped_q), .credit_flat(credit_flat)
);

// File: tb/credit_shaper_bench.sv
module credit_shaper_bench;
    localparam int     LEN_W = 11;
    localparam longint SEND  = 61036;
    localparam longint LO    = -40 * 61036;
    localparam longint BYTE_U = 2 * 32'h7735;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_queue = 1'b0, cfg_keep = 1'b0;
    logic [1:0]  cfg_sel = 2'b00;
    logic [15:0] cfg_idle_slope = '0;
    logic [31:0] cfg_hicredit = '0;
    logic [1:0]  pend = 2'b00;
    logic [2*LEN_W-1:0] flen = {11'd64, 11'd64};
    logic        tx_busy = 1'b0, byte_tick = 1'b0;
    logic [1:0]  grant;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    credit_shaper #(.LEN_W(LEN_W), .CW(36), .SEND_STEP(int'(SEND)), .LO_CREDIT(int'(LO))) u_credit_shaper (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_queue(cfg_queue),
        .cfg_sel(cfg_sel), .cfg_idle_slope(cfg_idle_slope), .cfg_keep(cfg_keep),
        .cfg_hicredit(cfg_hicredit), .frame_pending(pend), .frame_len(flen),
        .tx_busy(tx_busy), .byte_tick(byte_tick), .grant(grant)
    );

    function automatic longint rec_ticks(longint deficit, longint s);
        if (deficit <= 0) return 0;
        return (deficit + s - 1) / s;
    endfunction

    function automatic longint after_tx(longint c0, longint n);
        longint v = c0 - n * SEND;
        return (v < LO) ? LO : v;
    endfunction

    function automatic longint rise_cap(longint c, longint n, longint s, longint hi);
        longint v = c + n * s;
        return (v > hi) ? hi : v;
    endfunction

    function automatic logic [31:0] hi_word(int bytes);
        return 32'h8000_0000 + 32'(bytes) * 32'h7735;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_grant(input logic [1:0] exp, input string tag);
        check(grant === exp, tag, longint'(grant), longint'(exp));
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_once();
        byte_tick = 1'b1;
        cyc(1);
        byte_tick = 1'b0;
    endtask

    task automatic cfg_write(input bit q, input logic [1:0] sel, input int slope,
                             input bit keep, input logic [31:0] hi);
        cfg_queue = q; cfg_sel = sel; cfg_idle_slope = 16'(slope);
        cfg_keep = keep; cfg_hicredit = hi; cfg_wr = 1'b1;
        cyc(1);
        cfg_wr = 1'b0;
    endtask

    // Send a granted frame lasting n ticks; ends with the grant released.
    task automatic tx_frame(input int n);
        tx_busy = 1'b1;
        cyc(1);
        repeat (n) tick_once();
        tx_busy = 1'b0;
        cyc(1);
    endtask

    task automatic measure(input int q, output longint cnt);
        cnt = 500;
        for (int k = 0; k < 500; k++) begin
            if (grant[q]) begin
                cnt = k;
                break;
            end
            tick_once();
            cyc(1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        longint cnt, exp, c;
        int s, n;
        void'($urandom(32'd5150));
        cyc(3);
        chk_grant(2'b00, "R1 reset grant");
        rst_n = 1'b1;
        cyc(2);
        chk_grant(2'b00, "R1 idle after reset");

        // R2: unshaped queue granted when pending
        pend = 2'b01; cyc(2);
        chk_grant(2'b01, "R2 unshaped grant");
        // R4: grant held without tx_busy fall
        pend = 2'b00; cyc(3);
        chk_grant(2'b01, "R4 hold while idle");
        tx_busy = 1'b1; cyc(2);
        chk_grant(2'b01, "R4 hold while busy");
        tx_busy = 1'b0; cyc(1);
        chk_grant(2'b00, "R4 release after fall");
        // R3: priority
        pend = 2'b11; cyc(1);
        chk_grant(2'b01, "R3 queue 0 first");
        tx_frame(3); cyc(1);
        chk_grant(2'b01, "R2 unshaped regrant");
        pend = 2'b10; tx_frame(0); cyc(1);
        chk_grant(2'b10, "R3 queue 1 after queue 0 idle");
        // R2: zero length never eligible
        pend = 2'b00; tx_frame(0);
        flen[LEN_W-1:0] = '0; pend = 2'b01; cyc(3);
        chk_grant(2'b00, "R2 zero length");
        flen[LEN_W-1:0] = 11'd64; pend = 2'b00; cyc(1);

        // R6: queue 1 before queue 0 refused
        cfg_write(1'b1, 2'b11, 20000, 1'b0, hi_word(100));
        pend = 2'b10; cyc(1);
        chk_grant(2'b10, "R6 q1 grant");
        tx_frame(30); cyc(1);
        chk_grant(2'b10, "R6 q1 stays unshaped");
        // R5 and R7: bad codes and bit 31 clear refused
        cfg_write(1'b0, 2'b11, 20000, 1'b0, hi_word(100));
        cfg_write(1'b0, 2'b01, 20000, 1'b0, hi_word(100));
        cfg_write(1'b0, 2'b10, 20000, 1'b0, 32'h0000_1000);
        pend = 2'b00; tx_frame(0);
        pend = 2'b01; cyc(1);
        chk_grant(2'b01, "R5 q0 grant");
        tx_frame(30); cyc(1);
        chk_grant(2'b01, "R5 R7 q0 stays unshaped");

        // R8: random recovery
        for (int it = 0; it < 8; it++) begin
            s = int'($urandom_range(60000, 8000));
            n = int'($urandom_range(12, 1));
            cfg_write(1'b0, 2'b10, s, 1'b0, hi_word(1000));
            tx_frame(n);
            measure(0, cnt);
            exp = rec_ticks(-after_tx(0, n), s);
            check(cnt == exp, "R8 recovery ticks", cnt, exp);
        end
        // R9: floor
        cfg_write(1'b0, 2'b10, 20000, 1'b0, hi_word(1000));
        tx_frame(60);
        measure(0, cnt);
        exp = rec_ticks(-after_tx(0, 60), 20000);
        check(cnt == exp, "R9 low floor", cnt, exp);

        // R11: positive credit cleared or kept
        for (int kp = 0; kp < 2; kp++) begin
            cfg_write(1'b0, 2'b10, 20000, 1'b0, hi_word(100));
            if (kp == 1) cfg_write(1'b0, 2'b10, 20000, 1'b1, hi_word(100));
            pend = 2'b11;
            tx_frame(4); cyc(1);
            chk_grant(2'b10, "R8 negative queue skipped");
            tx_frame(20); cyc(1);
            c = rise_cap(after_tx(0, 4), 20, 20000, 100 * BYTE_U);
            pend = 2'b00;
            tick_once(); cyc(1);
            if (kp == 0) c = 0;
            pend = 2'b01; cyc(1);
            tx_frame(5);
            measure(0, cnt);
            exp = rec_ticks(-after_tx(c, 5), 20000);
            check(cnt == exp, kp == 0 ? "R11 credit cleared" : "R11 credit kept", cnt, exp);
        end

        // R10: ceiling while other queue transmits
        cfg_write(1'b1, 2'b11, 30000, 1'b0, hi_word(2));
        cfg_write(1'b0, 2'b10, 20000, 1'b0, hi_word(1000));
        pend = 2'b11;
        tx_frame(10); cyc(1);
        chk_grant(2'b10, "R10 q1 granted");
        pend = 2'b10;
        tx_frame(5);
        measure(1, cnt);
        c = rise_cap(0, 10, 30000, 2 * BYTE_U);
        exp = rec_ticks(-after_tx(c, 5), 30000);
        check(cnt == exp, "R10 R7 ceiling", cnt, exp);

        // R6: queue 0 disable while queue 1 shaped refused
        cfg_write(1'b0, 2'b00, 0, 1'b0, 32'h0);
        pend = 2'b00; tx_frame(0);
        pend = 2'b01; cyc(2);
        chk_grant(2'b00, "R6 q0 stays shaped");
        // R12: disable in legal order
        cfg_write(1'b1, 2'b00, 0, 1'b0, 32'h0);
        cfg_write(1'b0, 2'b00, 0, 1'b0, 32'h0);
        cyc(1);
        chk_grant(2'b01, "R12 q0 unshaped grant");
        tx_frame(10); cyc(1);
        chk_grant(2'b01, "R12 q0 regrant");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule